// File: doc/BRIEF.md
# 32-Source Cascadable Interrupt Controller

This unit gathers 32 interrupt sources into one latched status word and produces two request lines: a non-critical request and a critical request. A parent controller or a processor core consumes them. Each source has its own controls, set through a small register bus. These are the detection style (level or edge), the active sense (high/rising or low/falling), an enable, and a route selecting which of the two request lines the source drives. Software reads the latched status and the enabled pending word. It acknowledges a source by writing a one to that source's status bit.

Sources are brought in through a two-stage synchronizer, so external pins may be connected directly. Every register word uses reversed bit order: source n sits at word bit 31−n. Source 0 is therefore the most significant bit. In level mode a status bit keeps re-asserting while its input stays active. Software has to remove the cause before an acknowledge can stick. In edge mode the bit latches one event and holds it until acknowledged.

The register selects on `bus_addr` are: 0 status, 1 enable, 2 critical route, 3 sense, 4 detect style, 5 enabled pending (read-only). Reads are combinational from `bus_addr`. Writes take effect on the clock edge where `bus_we` is high.

Top module: `icu_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, the status, enable, route, sense and detect-style words read as zero and both request outputs are low.
- R2: Source n appears at word bit 31−n: source 0 at 0x8000_0000, source 31 at 0x0000_0001.
- R3: A write to select 0 clears every status bit where the data bit is 1. Bits written 0 keep their value, and writing 0xFFFF_FFFF clears all bits whose cause is gone.
- R4: With detect-style bit 0 (level), a status bit is set on every cycle its synchronized input is at its active level. It re-appears right after a clear while the input stays active, and a clear sticks only after the input goes inactive.
- R5: With detect-style bit 1 (edge), a status bit is set by the selected transition of the synchronized input: rising for sense 1, falling for sense 0. It stays set after the input returns, until cleared. The opposite transition sets nothing.
- R6: With detect style 0 and sense bit 0, a low input is active. After reset, with all inputs low, every status bit becomes set.
- R7: The enabled pending word (select 5) reads status AND enable, and writes to select 5 are ignored.
- R8: `irq_noncrit` is the registered OR of enabled pending bits whose route bit is 0, and `irq_crit` is the same for route bit 1. Each changes one clock after the enable, route or status change that causes it.
- R9: When a status clear and a new edge event for the same bit fall on the same clock, the bit ends up set.
- R10: The enable, route, sense and detect-style words read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 32 | Raw interrupt inputs, index n is source n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| irq_noncrit | output | 1 | Non-critical request output |
| irq_crit | output | 1 | Critical request output |

## Verification
The bench aims a clear at an edge-mode bit on exactly the clock where a fresh rising edge reaches the detector. A design that let the clear win would drop that interrupt. It acknowledges a level source while its input is still held. A design that treated level inputs as edge-latched would show the bit gone, while one with a sticky clear would never re-arm. It also checks the status bit that matches both ends of the source numbering, and that an opposite-direction edge sets nothing. On the outputs it samples the request lines in the cycle right after a change to enable, and again one cycle later. This catches a combinational or doubly delayed output and a swapped route.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int unsigned SRC_N  = 32;
    localparam int unsigned ADDR_W = 3;

    typedef logic [SRC_N-1:0] word_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STAT  = 3'd0,
        SEL_ENA   = 3'd1,
        SEL_CRIT  = 3'd2,
        SEL_SENSE = 3'd3,
        SEL_STYLE = 3'd4,
        SEL_PEND  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        word_t ena;
        word_t crit;
        word_t sense;
        word_t style;
    } cfg_t;

    // Source n lands on word bit SRC_N-1-n.
    function automatic word_t src_to_word(input word_t src);
        word_t w;
        for (int n = 0; n < SRC_N; n++) begin
            w[SRC_N-1-n] = src[n];
        end
        return w;
    endfunction

endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [DEPTH-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int k = DEPTH - 1; k > 0; k--) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/icu_detect.sv
module icu_detect
    import icu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t lvl,
    input  word_t sense,
    input  word_t style,
    output word_t evt
);
    word_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        logic active;
        logic moved;
        assign active = ~(lvl[i] ^ sense[i]);
        assign moved  = lvl[i] ^ prev[i];
        // style 1: edge toward the active level; style 0: level
        assign evt[i] = style[i] ? (active & moved) : active;
    end
endmodule

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  word_t             evt,
    input  word_t             pend,
    output cfg_t              cfg,
    output word_t             stat,
    output word_t             rdata
);
    reg_sel_e sel;
    word_t    clr_vec;

    assign sel     = reg_sel_e'(addr);
    assign clr_vec = (we && sel == SEL_STAT) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            // a new event overrides a same-cycle clear
            stat <= (stat & ~clr_vec) | evt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (sel)
                SEL_ENA:   cfg.ena   <= wdata;
                SEL_CRIT:  cfg.crit  <= wdata;
                SEL_SENSE: cfg.sense <= wdata;
                SEL_STYLE: cfg.style <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_STAT:  rdata = stat;
            SEL_ENA:   rdata = cfg.ena;
            SEL_CRIT:  rdata = cfg.crit;
            SEL_SENSE: rdata = cfg.sense;
            SEL_STYLE: rdata = cfg.style;
            SEL_PEND:  rdata = pend;
            default:   rdata = '0;
        endcase
    end

    // R3
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(stat) & ~$past(clr_vec) & ~stat) == '0));

    // R9
    event_lands_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(evt) & ~stat) == '0));

    // R1
    reset_stat_chk: assert property (@(posedge clk)
        rst |=> (stat == '0 && cfg == '0));
endmodule

// File: rtl/icu_out.sv
module icu_out
    import icu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t stat,
    input  word_t ena,
    input  word_t crit,
    output word_t pend,
    output logic  irq_nc,
    output logic  irq_cr
);
    assign pend = stat & ena;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_nc <= 1'b0;
            irq_cr <= 1'b0;
        end else begin
            irq_nc <= |(pend & ~crit);
            irq_cr <= |(pend & crit);
        end
    end

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ena == '0) |=> (!irq_nc && !irq_cr));

    // R8
    crit_unrouted_chk: assert property (@(posedge clk) disable iff (rst)
        (crit == '0) |=> !irq_cr);
endmodule

// File: rtl/icu_unit.sv
module icu_unit
    import icu_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  src_irq,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SRC_N-1:0]  bus_wdata,
    output logic [SRC_N-1:0]  bus_rdata,
    output logic              irq_noncrit,
    output logic              irq_crit
);
    word_t src_sync;
    word_t src_word;
    word_t evt;
    word_t stat;
    word_t pend;
    cfg_t  cfg;

    icu_sync #(.W(SRC_N), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_irq),
        .q   (src_sync)
    );

    assign src_word = src_to_word(src_sync);

    icu_detect u_det (
        .clk   (clk),
        .rst   (rst),
        .lvl   (src_word),
        .sense (cfg.sense),
        .style (cfg.style),
        .evt   (evt)
    );

    icu_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .evt   (evt),
        .pend  (pend),
        .cfg   (cfg),
        .stat  (stat),
        .rdata (bus_rdata)
    );

    icu_out u_out (
        .clk    (clk),
        .rst    (rst),
        .stat   (stat),
        .ena    (cfg.ena),
        .crit   (cfg.crit),
        .pend   (pend),
        .irq_nc (irq_noncrit),
        .irq_cr (irq_crit)
    );
endmodule

// File: tb/sim_icu_unit.sv
module sim_icu_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_irq = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_noncrit;
    logic        irq_crit;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        bit          is_out;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #10 clk = ~clk;

    icu_unit u0 (
        .clk(clk), .rst(rst), .src_irq(src_irq), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_noncrit(irq_noncrit), .irq_crit(irq_crit)
    );

    // monitor: pops expected items and compares with what the design shows
    initial begin
        forever begin
            sb_item_t it;
            logic [31:0] act;
            wait (sb.size() != 0);
            it  = sb.pop_front();
            act = it.is_out ? {30'b0, irq_crit, irq_noncrit} : bus_rdata;
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input bit is_out, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.is_out = is_out;
        it.exp    = exp;
        it.tag    = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic expect_reg(input logic [2:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = sel;
        #2;
        push(1'b0, exp, tag);
    endtask

    task automatic expect_out(input logic [1:0] exp, input string tag);
        @(negedge clk);
        #2;
        push(1'b1, {30'b0, exp}, tag);
    endtask

    task automatic expect_out_now(input logic [1:0] exp, input string tag);
        #2;
        push(1'b1, {30'b0, exp}, tag);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = sel;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_src(input logic [31:0] v);
        @(negedge clk);
        src_irq = v;
    endtask

    logic done = 1'b0;

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(2);
        // R1: reset state
        expect_reg(3'd0, 32'h0, "R1 status in reset");
        expect_reg(3'd1, 32'h0, "R1 enable in reset");
        expect_reg(3'd4, 32'h0, "R1 style in reset");
        expect_out(2'b00, "R1 outputs in reset");
        @(negedge clk);
        rst = 1'b0;
        expect_reg(3'd3, 32'h0, "R1 sense after reset");

        // R6: default level/active-low with inputs low sets every bit
        idle(4);
        expect_reg(3'd0, 32'hFFFF_FFFF, "R6 active-low level after reset");

        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd0, 32'hFFFF_FFFF);
        expect_reg(3'd0, 32'h0, "R3 all-ones clear");

        // R10 readback, R7 read-only pending word
        wr(3'd1, 32'hA5A5_0F0F);
        expect_reg(3'd1, 32'hA5A5_0F0F, "R10 enable readback");
        wr(3'd2, 32'h0000_FFFF);
        expect_reg(3'd2, 32'h0000_FFFF, "R10 route readback");
        wr(3'd5, 32'h1234_5678);
        expect_reg(3'd5, 32'h0, "R7 pending write ignored");
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h0);

        // R2: bit mapping at both ends
        drive_src(32'h0000_0001);
        idle(4);
        expect_reg(3'd0, 32'h8000_0000, "R2 source 0 at bit 31");
        drive_src(32'h0);
        idle(4);
        wr(3'd0, 32'hFFFF_FFFF);
        drive_src(32'h8000_0000);
        idle(4);
        expect_reg(3'd0, 32'h0000_0001, "R2 source 31 at bit 0");

        // R4: level re-asserts while held
        wr(3'd0, 32'h0000_0001);
        expect_reg(3'd0, 32'h0000_0001, "R4 level re-assert after clear");
        drive_src(32'h0);
        idle(4);
        wr(3'd0, 32'h0000_0001);
        expect_reg(3'd0, 32'h0, "R4 clear sticks once inactive");

        // R5 rising edge, sticky; R3 selective clear
        wr(3'd4, 32'hFFFF_FFFF);
        drive_src(32'h0000_0028);
        idle(4);
        expect_reg(3'd0, 32'h1400_0000, "R5 rising edges latched");
        drive_src(32'h0);
        idle(4);
        expect_reg(3'd0, 32'h1400_0000, "R5 sticky after input drop");
        wr(3'd0, 32'h1000_0000);
        expect_reg(3'd0, 32'h0400_0000, "R3 clear one bit only");
        wr(3'd0, 32'h0);
        expect_reg(3'd0, 32'h0400_0000, "R3 zero write no effect");
        wr(3'd0, 32'hFFFF_FFFF);

        // R5 falling edge with sense 0
        wr(3'd3, 32'hFEFF_FFFF);
        drive_src(32'h0000_0080);
        idle(4);
        expect_reg(3'd0, 32'h0, "R5 rising ignored for sense 0");
        drive_src(32'h0);
        idle(4);
        expect_reg(3'd0, 32'h0100_0000, "R5 falling edge latched");
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);

        // R7/R8 masking and routing (level mode)
        wr(3'd4, 32'h0);
        drive_src(32'h0000_0006);
        idle(4);
        expect_reg(3'd0, 32'h6000_0000, "R4 level sources pending");
        expect_reg(3'd5, 32'h0, "R7 disabled not pending");
        expect_out(2'b00, "R8 disabled no request");
        wr(3'd1, 32'h4000_0000);
        expect_reg(3'd5, 32'h4000_0000, "R7 pending is status and enable");
        idle(1);
        expect_out(2'b01, "R8 non-critical request");
        wr(3'd2, 32'h4000_0000);
        idle(1);
        expect_out(2'b10, "R8 critical request");
        wr(3'd1, 32'h6000_0000);
        idle(1);
        expect_out(2'b11, "R8 both requests");
        wr(3'd1, 32'h0);
        expect_out_now(2'b11, "R8 output registered one cycle");
        expect_out(2'b00, "R8 output drops after one cycle");
        wr(3'd2, 32'h0);
        drive_src(32'h0);
        idle(4);
        wr(3'd0, 32'hFFFF_FFFF);

        // R9 clear colliding with a new edge
        wr(3'd4, 32'hFFFF_FFFF);
        drive_src(32'h0000_0010);
        idle(4);
        expect_reg(3'd0, 32'h0800_0000, "R9 setup edge latched");
        drive_src(32'h0);
        idle(4);
        drive_src(32'h0000_0010);
        @(negedge clk);
        wr(3'd0, 32'h0800_0000);
        expect_reg(3'd0, 32'h0800_0000, "R9 event wins over clear");
        wr(3'd0, 32'h0800_0000);
        expect_reg(3'd0, 32'h0, "R3 clear without collision");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule